// File: doc/BRIEF.md
# Test Access Port with Shared Test-Pin Ownership

This block is a standard boundary-scan test access port controller with a small piece of logic that decides who owns the test clock, test data-in and test data-out pins. Those pins can also serve as ordinary user I/O. A static mode input chooses the policy. In dedicated mode the pins always belong to the test logic. In flexible mode they behave as user I/O until a test sequence claims them. A test sequence starts with a low TMS on a TCK rising edge. The pins stay claimed until the controller returns to its reset state, and then they go back to user I/O.

The controller walks the usual sixteen-state table. It samples TMS and TDI on the TCK rising edge and updates TDO on the falling edge. The data path is deliberately minimal. It has an instruction shift register that captures a fixed pattern, and a one-bit bypass register that every instruction selects. The pad drives TDO only while `tdo_oe` is high. `pins_owned` tells the pin multiplexers whether the shared pins belong to the test logic or to the user design.

Top module: `tap_pin_owner`

## Requirements
- R1: Either of two conditions resets the block at once, without waiting for a clock edge: `por_n` low, or `trst_en` high together with `trst_n` low. In reset the controller sits in the reset state (code 4'hF) and `tdo_oe` is 0. In flexible mode `pins_owned` is also 0 in reset.
- R2: `tap_state` follows the standard sixteen-state transition table on each TCK rising edge. The state codes are: reset F, idle C, select-DR 7, capture-DR 6, shift-DR 2, exit1-DR 1, pause-DR 3, exit2-DR 0, update-DR 5, select-IR 4, capture-IR E, shift-IR A, exit1-IR 9, pause-IR B, exit2-IR 8 and update-IR D.
- R3: Five consecutive TCK rising edges with TMS high bring the controller to the reset state from any state. Four such edges are not always enough.
- R4: In flexible mode (`dedicated_mode` = 0), a TCK rising edge with TMS low sets `pins_owned` to 1.
- R5: In flexible mode, `pins_owned` clears on the rising edge that moves the controller into the reset state. It stays 0 while TMS is held high in that state.
- R6: In dedicated mode (`dedicated_mode` = 1), `pins_owned` is 1 in every state, including the reset state.
- R7: When `trst_en` is 0, `trst_n` has no effect, and the controller keeps stepping on TCK.
- R8: `tdo_oe` is 1 only while the controller is in shift-DR or shift-IR and the pins are owned. It changes on the TCK falling edge.
- R9: Capture-IR loads the instruction register with 2'b01. In shift-IR the register shifts toward bit 0, TDI enters at the top bit, and bit 0 appears on TDO after each falling edge.
- R10: Capture-DR clears the bypass bit. In shift-DR each TDI bit reappears on TDO one TCK cycle later, and the first bit out is the captured 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| trst_n | input | 1 | Test reset pin, active low, used only when enabled |
| trst_en | input | 1 | 1 = `trst_n` acts as the test reset |
| dedicated_mode | input | 1 | 0 = flexible (default), 1 = pins always owned by test logic |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out value |
| tdo_oe | output | 1 | Output enable for the TDO pad |
| pins_owned | output | 1 | 1 = shared pins belong to the test logic |
| tap_state | output | 4 | Current controller state code |

## Verification
The bench builds the block with its default parameters: a 2-bit instruction register that captures 2'b01. With those values the capture pattern and the TDI data that follows it both reach TDO within four shift cycles, so a single short sequence checks the whole instruction path. A vector walk through every one of the sixteen states tests ownership being claimed and released in flexible mode. Directed runs then cover the five-edge reset from a shift state, the test reset with its enable on and off, and dedicated mode through a full round trip back to reset.

// File: rtl/tap_own_pkg.sv
package tap_own_pkg;
  typedef enum logic [3:0] {
    ST_EX2DR = 4'h0, ST_EX1DR = 4'h1, ST_SHDR  = 4'h2, ST_PSDR  = 4'h3,
    ST_SELIR = 4'h4, ST_UPDR  = 4'h5, ST_CAPDR = 4'h6, ST_SELDR = 4'h7,
    ST_EX2IR = 4'h8, ST_EX1IR = 4'h9, ST_SHIR  = 4'hA, ST_PSIR  = 4'hB,
    ST_IDLE  = 4'hC, ST_UPIR  = 4'hD, ST_CAPIR = 4'hE, ST_RESET = 4'hF
  } tap_state_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_own_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_d
);
  always_comb begin
    unique case (state_q)
      ST_RESET: state_d = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  state_d = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: state_d = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: state_d = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  state_d = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: state_d = tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  state_d = tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: state_d = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  state_d = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: state_d = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: state_d = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  state_d = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: state_d = tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  state_d = tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: state_d = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  state_d = tms ? ST_SELDR : ST_IDLE;
      default:  state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tap_pin_arbiter.sv
module tap_pin_arbiter
  import tap_own_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       dedicated_mode,
  input  logic       tms,
  input  tap_state_e state_d,
  output logic       owned
);
  logic claim_q;

  // A low TMS on a rising edge claims the pins; entering reset gives them back.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                   claim_q <= 1'b0;
    else if (state_d == ST_RESET) claim_q <= 1'b0;
    else if (!tms)                claim_q <= 1'b1;
  end

  assign owned = dedicated_mode | claim_q;
endmodule

// File: rtl/tap_scan_path.sv
module tap_scan_path
  import tap_own_pkg::*;
#(
  parameter int unsigned          IR_W    = 2,
  parameter logic [IR_W-1:0]      IR_CAPT = 2'b01
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state_q,
  output logic       tdo_q,
  output logic       shift_oe_q
);
  logic [IR_W-1:0] ir_sr;
  logic            byp_q;

  // Rising edge: capture and shift actions of the current state.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr <= IR_CAPT;
      byp_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CAPIR: ir_sr <= IR_CAPT;
        ST_SHIR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_CAPDR: byp_q <= 1'b0;
        ST_SHDR:  byp_q <= tdi;
        default: ;
      endcase
    end
  end

  // Falling edge: present the serial output and its enable.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q      <= 1'b0;
      shift_oe_q <= 1'b0;
    end else begin
      shift_oe_q <= (state_q == ST_SHIR) || (state_q == ST_SHDR);
      if (state_q == ST_SHIR)      tdo_q <= ir_sr[0];
      else if (state_q == ST_SHDR) tdo_q <= byp_q;
    end
  end
endmodule

// File: rtl/tap_pin_owner.sv
module tap_pin_owner
  import tap_own_pkg::*;
#(
  parameter int unsigned     IR_W    = 2,
  parameter logic [IR_W-1:0] IR_CAPT = 2'b01
) (
  input  logic       tck,
  input  logic       por_n,
  input  logic       trst_n,
  input  logic       trst_en,
  input  logic       dedicated_mode,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  output logic       pins_owned,
  output logic [3:0] tap_state
);
  tap_state_e st_q, st_d;
  logic       rst_n, shift_oe_q, owned;

  assign rst_n = por_n & ~(trst_en & ~trst_n);

  tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state_q(st_q), .state_d(st_d)
  );

  tap_pin_arbiter u_arb (
    .tck(tck), .rst_n(rst_n), .dedicated_mode(dedicated_mode),
    .tms(tms), .state_d(st_d), .owned(owned)
  );

  tap_scan_path #(.IR_W(IR_W), .IR_CAPT(IR_CAPT)) u_path (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state_q(st_q),
    .tdo_q(tdo), .shift_oe_q(shift_oe_q)
  );

  assign tdo_oe     = shift_oe_q & owned;
  assign pins_owned = owned;
  assign tap_state  = st_q;
endmodule

// File: rtl/tap_pin_owner_chk.sv
module tap_pin_owner_chk (
  input logic       tck,
  input logic       por_n,
  input logic       trst_n,
  input logic       trst_en,
  input logic       dedicated_mode,
  input logic       tms,
  input logic       tdo_oe,
  input logic       pins_owned,
  input logic [3:0] tap_state
);
  logic       live;
  logic [2:0] hi_run;

  assign live = por_n & ~(trst_en & ~trst_n);

  always_ff @(posedge tck or negedge live) begin
    if (!live)             hi_run <= 3'd0;
    else if (!tms)         hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  // R6
  ded_owned_chk: assert property (@(posedge tck) disable iff (!live)
    dedicated_mode |-> pins_owned);

  // R4
  claim_chk: assert property (@(posedge tck) disable iff (!live)
    (!dedicated_mode && !tms) |=> pins_owned);

  // R5
  release_chk: assert property (@(posedge tck) disable iff (!live)
    (!dedicated_mode && tms && (tap_state == 4'h4 || tap_state == 4'hF))
      |=> (tap_state == 4'hF && !pins_owned));

  // R8
  oe_shift_chk: assert property (@(posedge tck) disable iff (!live)
    tdo_oe |-> (pins_owned && (tap_state == 4'h2 || tap_state == 4'hA)));

  // R3
  five_high_chk: assert property (@(posedge tck) disable iff (!live)
    (hi_run == 3'd5) |-> (tap_state == 4'hF));
endmodule

bind tap_pin_owner tap_pin_owner_chk u_chk (
  .tck(tck), .por_n(por_n), .trst_n(trst_n), .trst_en(trst_en),
  .dedicated_mode(dedicated_mode), .tms(tms), .tdo_oe(tdo_oe),
  .pins_owned(pins_owned), .tap_state(tap_state)
);

// File: tb/tap_pin_owner_test.sv
module tap_pin_owner_test;
  logic       tck = 1'b0;
  logic       por_n = 1'b0, trst_n = 1'b1, trst_en = 1'b1, dedicated_mode = 1'b0;
  logic       tms = 1'b1, tdi = 1'b0;
  logic       tdo, tdo_oe, pins_owned;
  logic [3:0] tap_state;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  tap_pin_owner uut (
    .tck(tck), .por_n(por_n), .trst_n(trst_n), .trst_en(trst_en),
    .dedicated_mode(dedicated_mode), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .pins_owned(pins_owned), .tap_state(tap_state)
  );

  always #10 tck = ~tck;

  // {tms, tdi, state[3:0], owned, oe, tdo}; tdo is checked only when oe is 1
  localparam int NV = 29;
  localparam logic [8:0] VEC [NV] = '{
    {2'b10, 4'hF, 3'b000}, {2'b00, 4'hC, 3'b100}, {2'b10, 4'h7, 3'b100},
    {2'b00, 4'h6, 3'b100}, {2'b00, 4'h2, 3'b110}, {2'b01, 4'h2, 3'b111},
    {2'b00, 4'h2, 3'b110}, {2'b11, 4'h1, 3'b100}, {2'b00, 4'h3, 3'b100},
    {2'b10, 4'h0, 3'b100}, {2'b00, 4'h2, 3'b111}, {2'b10, 4'h1, 3'b100},
    {2'b10, 4'h5, 3'b100}, {2'b10, 4'h7, 3'b100}, {2'b10, 4'h4, 3'b100},
    {2'b00, 4'hE, 3'b100}, {2'b00, 4'hA, 3'b111}, {2'b00, 4'hA, 3'b110},
    {2'b01, 4'hA, 3'b110}, {2'b00, 4'hA, 3'b111}, {2'b10, 4'h9, 3'b100},
    {2'b00, 4'hB, 3'b100}, {2'b10, 4'h8, 3'b100}, {2'b10, 4'hD, 3'b100},
    {2'b00, 4'hC, 3'b100}, {2'b10, 4'h7, 3'b100}, {2'b10, 4'h4, 3'b100},
    {2'b10, 4'hF, 3'b000}, {2'b10, 4'hF, 3'b000}
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); #5;
    @(negedge tck); #2;
  endtask

  task automatic do_reset(input logic ded);
    por_n = 1'b0; dedicated_mode = ded; tms = 1'b1;
    #3;
    por_n = 1'b1;
  endtask

  initial begin
    #27;
    // R1 reset state while power-on reset is held
    por_n = 1'b0;
    #1;
    check("R1 state", tap_state, 4'hF);
    check("R1 owned", {3'b0, pins_owned}, 4'h0);
    check("R1 oe", {3'b0, tdo_oe}, 4'h0);
    por_n = 1'b1;

    // R2 R4 R5 R8 R9 R10 walk of all sixteen states in flexible mode
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][8], VEC[i][7]);
      check($sformatf("R2 state step %0d", i), tap_state, VEC[i][6:3]);
      check($sformatf("R4/R5 owned step %0d", i), {3'b0, pins_owned}, {3'b0, VEC[i][2]});
      check($sformatf("R8 oe step %0d", i), {3'b0, tdo_oe}, {3'b0, VEC[i][1]});
      if (VEC[i][1])
        check($sformatf("R9/R10 tdo step %0d", i), {3'b0, tdo}, {3'b0, VEC[i][0]});
    end

    // R3 five TMS-high edges from shift-IR
    tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check("R3 in shift-IR", tap_state, 4'hA);
    for (int k = 0; k < 4; k++) tick(1, 0);
    check("R3 after four", tap_state, 4'h4);
    tick(1, 0);
    check("R3 after five", tap_state, 4'hF);
    check("R5 released", {3'b0, pins_owned}, 4'h0);

    // R1 asynchronous test reset with the enable set
    tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0);
    check("R1 pre exit1-DR", tap_state, 4'h1);
    trst_n = 1'b0;
    #1;
    check("R1 trst state", tap_state, 4'hF);
    check("R1 trst owned", {3'b0, pins_owned}, 4'h0);
    trst_n = 1'b1;

    // R7 test reset ignored with the enable clear
    tick(0, 0);
    check("R7 idle", tap_state, 4'hC);
    trst_en = 1'b0; trst_n = 1'b0;
    #1;
    check("R7 no reset", tap_state, 4'hC);
    tick(1, 0);
    check("R7 still steps", tap_state, 4'h7);
    check("R7 still owned", {3'b0, pins_owned}, 4'h1);
    trst_n = 1'b1; trst_en = 1'b1;

    // R6 dedicated mode owns pins everywhere
    do_reset(1'b1);
    check("R6 reset state", tap_state, 4'hF);
    check("R6 owned in reset", {3'b0, pins_owned}, 4'h1);
    tick(1, 0);
    check("R6 owned idle TMS", {3'b0, pins_owned}, 4'h1);
    tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check("R6 shift-DR oe", {3'b0, tdo_oe}, 4'h1);
    check("R10 captured zero", {3'b0, tdo}, 4'h0);
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    check("R6 back in reset", tap_state, 4'hF);
    check("R6 owned after return", {3'b0, pins_owned}, 4'h1);

    // R5 flexible mode after reset keeps pins while TMS stays high
    do_reset(1'b0);
    tick(1, 0); tick(1, 0);
    check("R5 idle high owned", {3'b0, pins_owned}, 4'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule